// File: doc/BRIEF.md
# ADC Result Correction Pipeline

This block turns raw signed samples from a decimation filter into finished 16-bit ADC codes. A sample arrives with a valid strobe. If chopping is enabled, two consecutive samples are paired and averaged, and only the pair produces a result. The value that results then goes through four steps in a fixed order. A signed offset coefficient is subtracted. The difference is scaled by an unsigned gain coefficient. The scaled value is rounded to 16 bits and clamped to full scale. Last, it is coded as two's complement or as offset binary.

The block fits between a decimation filter and whatever consumes converted results. The two 16-bit coefficient words and the format select come from configuration state outside the block. The coefficients and the format select are read while a sample moves through the stages. They must therefore be held steady from the cycle a sample enters until its result appears. The pipeline does not stall, and every result appears a fixed number of cycles after the sample that completes it.

Top module: `adc_result_corrector`

## Requirements
- R1: After reset, `res_valid` is low and `res_data` is zero until a result is produced.
- R2: A result appears on `res_valid`/`res_data` exactly 3 clock cycles after the edge at which the completing sample was accepted with `smp_valid` high.
- R3: With `chop_en` low, every accepted sample produces exactly one result, computed from that sample alone.
- R4: With `chop_en` high, accepted samples are paired. The first sample of a pair produces no result. The second sample produces one result from floor((first + second) / 2), and the next sample starts a new pair.
- R5: Any clock edge at which `chop_en` is low discards a pending unpaired first sample. The next chopped sample then starts a fresh pair.
- R6: The offset coefficient is a 16-bit two's complement value, expressed in sample LSBs. It is subtracted from the (averaged) sample.
- R7: The gain coefficient is a 16-bit unsigned value, where 0x8000 means unity. The difference is multiplied by the gain, and the product is shifted right (floor) by 15.
- R8: The scaled 24-bit value is reduced to 16 bits by dropping its 8 low bits with round-half-up: 128 is added before an arithmetic shift right by 8.
- R9: Rounded values above 32767 give 0x7FFF, and values below -32768 give 0x8000. Results saturate and never wrap.
- R10: With `fmt_offset_bin` = 0, the result is two's complement. With `fmt_offset_bin` = 1, bit 15 of the clamped two's complement result is inverted, which gives offset binary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_valid | input | 1 | Filter sample strobe |
| smp_data | input | 24 | Signed filter sample |
| chop_en | input | 1 | Pairwise averaging enable |
| fmt_offset_bin | input | 1 | 0: two's complement, 1: offset binary |
| offset_coef | input | 16 | Signed offset coefficient |
| gain_coef | input | 16 | Unsigned gain coefficient, 0x8000 = 1.0 |
| res_valid | output | 1 | Result strobe |
| res_data | output | 16 | Corrected ADC code |

## Verification
The bench builds the block with its default parameters: 24-bit samples, 16-bit coefficients and output, and a gain binary point of 15. With these values exactly 8 low bits are dropped at the rounding step, so half-LSB ties at plus and minus 128 can be hit precisely. A gain of 0xFFFF nearly doubles a full-scale sample, so both saturation limits are reached. The default chop support also brings pair formation, interrupted pairs and gapped pairs into reach under a free-running sample stream.

// File: rtl/adc_corr_pkg.sv
package adc_corr_pkg;
   typedef enum logic {
      CODE_TWOS   = 1'b0,
      CODE_OFFBIN = 1'b1
   } out_code_e;

   // Bits discarded between the raw product and the output code.
   function automatic int drop_bits(input int frac_w, input int smp_w, input int out_w);
      return frac_w + smp_w - out_w;
   endfunction
endpackage

// File: rtl/adc_chop_avg.sv
module adc_chop_avg #(
   parameter int SAMPLE_W     = 24,
   parameter bit CHOP_SUPPORT = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                in_valid,
   input  logic [SAMPLE_W-1:0] in_sample,
   input  logic                chop_en,
   output logic                s1_valid,
   output logic [SAMPLE_W-1:0] s1_data
);
   localparam int SUM_W = SAMPLE_W + 1;

   initial begin
      assert (SAMPLE_W >= 2) else $error("adc_chop_avg: SAMPLE_W too small");
   end

   logic s1_pair_q;

   generate
      if (CHOP_SUPPORT) begin : g_chop
         logic                half_q;
         logic [SAMPLE_W-1:0] first_q;
         logic [SUM_W-1:0]    pair_sum;

         assign pair_sum = {first_q[SAMPLE_W-1], first_q}
                         + {in_sample[SAMPLE_W-1], in_sample};

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               half_q    <= 1'b0;
               first_q   <= '0;
               s1_valid  <= 1'b0;
               s1_pair_q <= 1'b0;
               s1_data   <= '0;
            end else begin
               s1_valid  <= 1'b0;
               s1_pair_q <= 1'b0;
               if (!chop_en) begin
                  half_q <= 1'b0;
               end
               if (in_valid) begin
                  if (chop_en) begin
                     if (half_q) begin
                        s1_valid  <= 1'b1;
                        s1_pair_q <= 1'b1;
                        s1_data   <= pair_sum[SUM_W-1:1];
                        half_q    <= 1'b0;
                     end else begin
                        first_q <= in_sample;
                        half_q  <= 1'b1;
                     end
                  end else begin
                     s1_valid <= 1'b1;
                     s1_data  <= in_sample;
                  end
               end
            end
         end

         // R4
         pair_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (s1_valid && s1_pair_q) |=> !(s1_valid && s1_pair_q))
            else $error("paired results on adjacent cycles");
      end else begin : g_nochop
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               s1_valid  <= 1'b0;
               s1_pair_q <= 1'b0;
               s1_data   <= '0;
            end else begin
               s1_valid  <= in_valid;
               s1_pair_q <= 1'b0;
               if (in_valid) begin
                  s1_data <= in_sample;
               end
            end
         end
         logic unused_chop;
         assign unused_chop = chop_en;
      end
   endgenerate

   // R3
   pass_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !chop_en) |=> s1_valid)
      else $error("unchopped sample produced no stage-one value");
endmodule

// File: rtl/adc_offset_gain.sv
module adc_offset_gain #(
   parameter int SAMPLE_W = 24,
   parameter int COEF_W   = 16
) (
   input  logic                                 clk,
   input  logic                                 rst_n,
   input  logic                                 s1_valid,
   input  logic [SAMPLE_W-1:0]                  s1_data,
   input  logic [COEF_W-1:0]                    offset_coef,
   input  logic [COEF_W-1:0]                    gain_coef,
   output logic                                 s2_valid,
   output logic [SAMPLE_W+COEF_W+1:0]           s2_prod
);
   localparam int PROD_W = SAMPLE_W + COEF_W + 2;

   initial begin
      assert (SAMPLE_W >= COEF_W) else $error("adc_offset_gain: sample narrower than coefficient");
   end

   logic [PROD_W-1:0] diff_x;
   logic [PROD_W-1:0] gain_x;
   logic [PROD_W-1:0] prod_c;

   always_comb begin
      diff_x = {{(PROD_W-SAMPLE_W){s1_data[SAMPLE_W-1]}}, s1_data}
             - {{(PROD_W-COEF_W){offset_coef[COEF_W-1]}}, offset_coef};
      gain_x = {{(PROD_W-COEF_W){1'b0}}, gain_coef};
      prod_c = diff_x * gain_x;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         s2_valid <= 1'b0;
         s2_prod  <= '0;
      end else begin
         s2_valid <= s1_valid;
         if (s1_valid) begin
            s2_prod <= prod_c;
         end
      end
   end
endmodule

// File: rtl/adc_round_clamp.sv
module adc_round_clamp
   import adc_corr_pkg::*;
#(
   parameter int PROD_W    = 42,
   parameter int SAMPLE_W  = 24,
   parameter int OUT_W     = 16,
   parameter int GAIN_FRAC = 15
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              s2_valid,
   input  logic [PROD_W-1:0] s2_prod,
   input  logic              fmt_sel,
   output logic              res_valid,
   output logic [OUT_W-1:0]  res_data
);
   localparam int DROP = drop_bits(GAIN_FRAC, SAMPLE_W, OUT_W);
   localparam logic [PROD_W-1:0] RND_HALF = {{(PROD_W-1){1'b0}}, 1'b1} << (DROP-1);
   localparam logic [PROD_W-1:0] POS_FS = {{(PROD_W-OUT_W+1){1'b0}}, {(OUT_W-1){1'b1}}};
   localparam logic [PROD_W-1:0] NEG_FS = {{(PROD_W-OUT_W+1){1'b1}}, {(OUT_W-1){1'b0}}};

   initial begin
      assert (DROP >= 1) else $error("adc_round_clamp: nothing to round away");
      assert (PROD_W > OUT_W + DROP) else $error("adc_round_clamp: product too narrow");
   end

   logic signed [PROD_W-1:0] rnd_s;
   logic signed [PROD_W-1:0] shr_s;
   logic        [OUT_W-1:0]  clamp_c;
   out_code_e                code_sel;

   assign code_sel = out_code_e'(fmt_sel);

   always_comb begin
      rnd_s = $signed(s2_prod) + $signed(RND_HALF);
      shr_s = rnd_s >>> DROP;
      if (shr_s > $signed(POS_FS)) begin
         clamp_c = POS_FS[OUT_W-1:0];
      end else if (shr_s < $signed(NEG_FS)) begin
         clamp_c = NEG_FS[OUT_W-1:0];
      end else begin
         clamp_c = shr_s[OUT_W-1:0];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         res_valid <= 1'b0;
         res_data  <= '0;
      end else begin
         res_valid <= s2_valid;
         if (s2_valid) begin
            if (code_sel == CODE_OFFBIN) begin
               res_data <= {~clamp_c[OUT_W-1], clamp_c[OUT_W-2:0]};
            end else begin
               res_data <= clamp_c;
            end
         end
      end
   end

   // R9
   sign_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (s2_valid && !s2_prod[PROD_W-1]) |=> (res_data[OUT_W-1] == $past(fmt_sel)))
      else $error("non-negative product produced a wrapped code");
endmodule

// File: rtl/adc_result_corrector.sv
module adc_result_corrector #(
   parameter int SAMPLE_W     = 24,
   parameter int COEF_W       = 16,
   parameter int OUT_W        = 16,
   parameter int GAIN_FRAC    = 15,
   parameter bit CHOP_SUPPORT = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                smp_valid,
   input  logic [SAMPLE_W-1:0] smp_data,
   input  logic                chop_en,
   input  logic                fmt_offset_bin,
   input  logic [COEF_W-1:0]   offset_coef,
   input  logic [COEF_W-1:0]   gain_coef,
   output logic                res_valid,
   output logic [OUT_W-1:0]    res_data
);
   localparam int PROD_W = SAMPLE_W + COEF_W + 2;

   initial begin
      assert (SAMPLE_W > OUT_W) else $error("adc_result_corrector: sample must exceed output width");
      assert (GAIN_FRAC < COEF_W) else $error("adc_result_corrector: gain binary point out of range");
   end

   logic                s1_valid;
   logic [SAMPLE_W-1:0] s1_data;
   logic                s2_valid;
   logic [PROD_W-1:0]   s2_prod;

   adc_chop_avg #(
      .SAMPLE_W     (SAMPLE_W),
      .CHOP_SUPPORT (CHOP_SUPPORT)
   ) u_chop (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (smp_valid),
      .in_sample (smp_data),
      .chop_en   (chop_en),
      .s1_valid  (s1_valid),
      .s1_data   (s1_data)
   );

   adc_offset_gain #(
      .SAMPLE_W (SAMPLE_W),
      .COEF_W   (COEF_W)
   ) u_scale (
      .clk         (clk),
      .rst_n       (rst_n),
      .s1_valid    (s1_valid),
      .s1_data     (s1_data),
      .offset_coef (offset_coef),
      .gain_coef   (gain_coef),
      .s2_valid    (s2_valid),
      .s2_prod     (s2_prod)
   );

   adc_round_clamp #(
      .PROD_W    (PROD_W),
      .SAMPLE_W  (SAMPLE_W),
      .OUT_W     (OUT_W),
      .GAIN_FRAC (GAIN_FRAC)
   ) u_fmt (
      .clk       (clk),
      .rst_n     (rst_n),
      .s2_valid  (s2_valid),
      .s2_prod   (s2_prod),
      .fmt_sel   (fmt_offset_bin),
      .res_valid (res_valid),
      .res_data  (res_data)
   );

   // R2
   fixed_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |-> $past(smp_valid, 3))
      else $error("result without a sample three cycles earlier");
endmodule

// File: tb/tb_adc_result_corrector.sv
module tb_adc_result_corrector;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        smp_valid = 1'b0;
   logic [23:0] smp_data = '0;
   logic        chop_en = 1'b0;
   logic        fmt_offset_bin = 1'b0;
   logic [15:0] offset_coef = '0;
   logic [15:0] gain_coef = 16'h8000;
   logic        res_valid;
   logic [15:0] res_data;

   always #5 clk = ~clk;

   adc_result_corrector dut (
      .clk            (clk),
      .rst_n          (rst_n),
      .smp_valid      (smp_valid),
      .smp_data       (smp_data),
      .chop_en        (chop_en),
      .fmt_offset_bin (fmt_offset_bin),
      .offset_coef    (offset_coef),
      .gain_coef      (gain_coef),
      .res_valid      (res_valid),
      .res_data       (res_data)
   );

   int    checks = 0;
   int    fails  = 0;
   string cur_req = "R1";
   bit    running = 1'b0;
   bit    finished = 1'b0;

   bit          pv [3];
   logic [15:0] pd [3];
   bit          have_first = 1'b0;
   longint      first_smp = 0;

   function automatic logic [15:0] ref_code(input longint x);
      longint diff, prod, scaled, rounded;
      logic [15:0] c;
      diff    = x - longint'($signed(offset_coef));
      prod    = diff * longint'(gain_coef);
      scaled  = prod >>> 15;
      rounded = (scaled + 128) >>> 8;
      if (rounded > 32767) rounded = 32767;
      if (rounded < -32768) rounded = -32768;
      c = rounded[15:0];
      if (fmt_offset_bin) c[15] = ~c[15];
      return c;
   endfunction

   // Behavioural reference, advanced on every rising edge.
   always @(posedge clk) begin
      bit          nv;
      logic [15:0] nd;
      longint      s;
      nv = 1'b0;
      nd = '0;
      s  = longint'($signed(smp_data));
      if (!rst_n) begin
         have_first = 1'b0;
         foreach (pv[i]) begin pv[i] = 1'b0; pd[i] = '0; end
      end else begin
         if (smp_valid && chop_en) begin
            if (have_first) begin
               nv = 1'b1;
               nd = ref_code((first_smp + s) >>> 1);
               have_first = 1'b0;
            end else begin
               first_smp  = s;
               have_first = 1'b1;
            end
         end else if (smp_valid) begin
            nv = 1'b1;
            nd = ref_code(s);
            have_first = 1'b0;
         end else if (!chop_en) begin
            have_first = 1'b0;
         end
         pv[2] = pv[1]; pd[2] = pd[1];
         pv[1] = pv[0]; pd[1] = pd[0];
         pv[0] = nv;    pd[0] = nd;
      end
   end

   // Compare on every falling edge.
   always @(negedge clk) begin
      if (running) begin
         checks++;
         if (res_valid !== pv[2] || (pv[2] && res_data !== pd[2])) begin
            fails++;
            $display("FAIL %s: valid=%0b data=%h, expected valid=%0b data=%h",
                     cur_req, res_valid, res_data, pv[2], pd[2]);
         end
      end
   end

   task automatic push(input logic [23:0] s);
      smp_valid = 1'b1;
      smp_data  = s;
      @(negedge clk);
      smp_valid = 1'b0;
   endtask

   task automatic idle(input int n);
      smp_valid = 1'b0;
      repeat (n) @(negedge clk);
   endtask

   task automatic set_cfg(input logic [15:0] off, input logic [15:0] g, input logic f);
      idle(4);
      offset_coef    = off;
      gain_coef      = g;
      fmt_offset_bin = f;
      idle(1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      checks++;
      if (res_valid !== 1'b0 || res_data !== 16'h0000) begin
         fails++;
         $display("FAIL R1: valid=%0b data=%h, expected valid=0 data=0000", res_valid, res_data);
      end
      rst_n = 1'b1;
      @(negedge clk);
      checks++;
      if (res_valid !== 1'b0 || res_data !== 16'h0000) begin
         fails++;
         $display("FAIL R1: valid=%0b data=%h, expected valid=0 data=0000", res_valid, res_data);
      end
      running = 1'b1;

      // R2: single isolated sample, latency observed by per-cycle compare
      cur_req = "R2";
      push(24'h012345);
      idle(5);

      // R8: rounding ties and boundaries at unity gain
      cur_req = "R8";
      push(24'h000080); push(24'h00007F); push(24'hFFFF80);
      push(24'hFFFF7F); push(24'h000180); push(24'hFFFE80);
      idle(4);

      // R3: back-to-back unchopped stream
      cur_req = "R3";
      for (int i = 0; i < 12; i++) push(24'(i * 24'h031F07 - 24'h200000));
      idle(4);

      // R6: offset positive and negative
      cur_req = "R6";
      set_cfg(16'h0100, 16'h8000, 1'b0);
      push(24'h001000); push(24'h000100); push(24'hFFF000);
      set_cfg(16'hFF00, 16'h8000, 1'b0);
      push(24'h001000); push(24'hFFFF00); push(24'h000000);
      set_cfg(16'h7FFF, 16'h8000, 1'b0);
      push(24'h000000); push(24'h7FFFFF);

      // R7: gain values
      cur_req = "R7";
      set_cfg(16'h0000, 16'h4000, 1'b0);
      push(24'h123456); push(24'hEDCBAA); push(24'h000300);
      set_cfg(16'h0000, 16'hFFFF, 1'b0);
      push(24'h123456); push(24'hEDCBAA); push(24'h000080);
      set_cfg(16'h0010, 16'h0000, 1'b0);
      push(24'h7FFFFF); push(24'h800000);

      // R9: saturation
      cur_req = "R9";
      set_cfg(16'h0000, 16'hFFFF, 1'b0);
      push(24'h7FFFFF); push(24'h800000); push(24'h400000); push(24'hC00000);
      set_cfg(16'h8000, 16'hFFFF, 1'b0);
      push(24'h7FFFFF); push(24'h000000);
      set_cfg(16'h7FFF, 16'hFFFF, 1'b0);
      push(24'h800000);

      // R10: offset-binary coding
      cur_req = "R10";
      set_cfg(16'h0000, 16'h8000, 1'b1);
      push(24'h000000); push(24'h7FFFFF); push(24'h800000);
      push(24'h000100); push(24'hFFFF00); push(24'h3456AB);
      set_cfg(16'h0000, 16'hFFFF, 1'b1);
      push(24'h7FFFFF); push(24'h800000);

      // R4: chopped pairs, back-to-back and gapped
      cur_req = "R4";
      set_cfg(16'h0020, 16'h8000, 1'b0);
      chop_en = 1'b1;
      push(24'h000101); push(24'h000202);
      push(24'hFFFFFF); push(24'h000000);
      push(24'h7FFFFF); push(24'h7FFFFF);
      push(24'h800000); push(24'h800000);
      push(24'h001000); idle(3); push(24'h003001);
      idle(4);

      // R5: interrupted pairs
      cur_req = "R5";
      push(24'h100000);
      chop_en = 1'b0; idle(1); chop_en = 1'b1;
      push(24'h000400); push(24'h000600);
      push(24'h222222);
      chop_en = 1'b0;
      push(24'h000900);
      chop_en = 1'b1;
      push(24'h000A00); push(24'h000C00);
      idle(4);

      // R3: mixed stream with random chop and gaps
      cur_req = "R3";
      set_cfg(16'hFF80, 16'h9A00, 1'b0);
      for (int i = 0; i < 300; i++) begin
         chop_en = ($urandom % 4) != 0;
         if (($urandom % 5) == 0) idle(1);
         else push(24'($urandom));
      end
      chop_en = 1'b0;
      idle(6);

      running  = 1'b0;
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         fails++;
         $display("FAIL watchdog: run did not complete, expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end
endmodule